// File: doc/BRIEF.md
# Center-Aligned PWM Carrier with Mid-On-Time Sampling Trigger

This block produces a symmetric (up/down) PWM carrier for a motor inverter. It counts from zero up to a programmable period, then back down to zero, and drives its output high whenever the carrier sits below the active compare value. The on-time is therefore centered on the carrier valley. For a continuous inductive load, the instantaneous link current at that valley equals the average winding current.

A half-period repetition counter raises an update event once every REP+1 half-periods. On that event the buffered duty value moves into the active compare. When the event lands on the valley, a one-cycle sample strobe also tells an external converter to capture the link current at the on-time midpoint. A prescaler, built as a clock enable, slows the carrier by 1, 2, 4 or 8. The carrier frequency is clk / (divide × 2 × period).

Top module: `cpwm_midsample`

## Requirements
- R1: While period P is nonzero, the carrier moves one step per enabled tick through 0, 1, …, P, P-1, …, 1 and back to 0, so one carrier period lasts 2·P ticks. With P = 0 the carrier holds at 0 and produces no half-period boundaries.
- R2: `presc_sel` codes 0, 1, 2 and 3 give one tick every 1, 2, 4 and 8 clocks. The gap between two sample strobes with REP = 1 is therefore 2·P·divide clocks.
- R3: `pwm_o` is high exactly in the clock cycles where the carrier value is strictly less than the active compare. Over one carrier period a compare c with 1 ≤ c ≤ P gives (2c−1)·divide high clocks.
- R4: An active compare of 0 keeps `pwm_o` low for the whole period. An active compare above P keeps it high for the whole period.
- R5: A half-period boundary is the cycle in which the carrier arrives at 0 or at P. `upd_o` pulses for one clock on every (REP+1)-th boundary. After reset the first pulse comes at the first return to 0, which is 2·P·divide clocks after reset is released.
- R6: `samp_o` pulses only in an `upd_o` cycle where the carrier is at 0. With odd REP every update is sampled. With even REP, updates alternate between valley (sampled) and peak (not sampled).
- R7: `duty_shadow_i` is copied into the active compare only at the clock edge that ends an `upd_o` cycle. A change at any other time has no effect on `pwm_o` until the next update.
- R8: The repetition counter reloads from `rep_i` at each update. A new REP value changes the spacing only from the next reload onward.
- R9: While `rst_n` is low (synchronous), the carrier is at 0 and counting up, the active compare is 0, and `pwm_o`, `upd_o` and `samp_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_sel | input | 2 | Tick divide select: 0→1, 1→2, 2→4, 3→8 |
| period_i | input | 12 | Carrier top value P |
| rep_i | input | 8 | Half-periods per update, minus one (REP) |
| duty_shadow_i | input | 12 | Buffered compare value |
| pwm_o | output | 1 | PWM output, high while carrier < active compare |
| upd_o | output | 1 | One-clock update event |
| samp_o | output | 1 | One-clock current-sample strobe (update at valley) |

## Verification
The bench aims at the places where a symmetric counter usually goes wrong:
- The turn-around at 0 and at P. A design that repeats or skips an endpoint shows wrong high-time counts and wrong strobe spacing.
- Even REP values. A design that samples at peak updates, or that never places an update on a peak, shows the wrong number of sample strobes.
- Compare values of 0, exactly P, and above P. These probe the strict less-than comparison.
- A duty or REP change written between updates. If it leaks through at once, `pwm_o` or the update spacing changes before the next reload.

// File: rtl/mp_pkg.sv
// Shared types for the center-aligned PWM block.
package mp_pkg;
    typedef enum logic { DIR_UP = 1'b0, DIR_DN = 1'b1 } dir_e;
endpackage

// File: rtl/mp_tick_gen.sv
// Prescaler: emits a one-clock enable every 2**sel clocks.
// Assumes sel may change at any time; an out-of-range phase wraps at once.
module mp_tick_gen #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (2 ** SEL_W) - 1;

    logic [DIV_W-1:0] phase;
    logic [DIV_W:0]   one_sh;
    logic [DIV_W:0]   lim_full;
    logic [DIV_W-1:0] limit;

    // Terminal phase value for the selected divide.
    always_comb begin
        one_sh   = {{DIV_W{1'b0}}, 1'b1} << sel;
        lim_full = one_sh - 1'b1;
        limit    = lim_full[DIV_W-1:0];
        tick     = (phase >= limit);
    end

    // Phase counter, cleared on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/mp_carrier.sv
// Up/down carrier: 0 .. period .. 0, one step per tick.
// Flags the cycle in which the value arrives at the valley or the peak.
module mp_carrier
    import mp_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             valley_hit,
    output logic             peak_hit
);
    dir_e             dir, dir_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             live;

    // Next carrier value and direction.
    always_comb begin
        live   = (period != '0);
        cnt_nx = cnt;
        dir_nx = dir;
        if (!live) begin
            cnt_nx = '0;
            dir_nx = DIR_UP;
        end else if (dir == DIR_UP) begin
            if (cnt >= period) begin
                dir_nx = DIR_DN;
                cnt_nx = cnt - 1'b1;
            end else begin
                cnt_nx = cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                dir_nx = DIR_UP;
                cnt_nx = {{(CNT_W-1){1'b0}}, 1'b1};
            end else begin
                cnt_nx = cnt - 1'b1;
            end
        end
    end

    // Carrier state and boundary flags, advanced only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            dir        <= DIR_UP;
            valley_hit <= 1'b0;
            peak_hit   <= 1'b0;
        end else if (tick) begin
            cnt        <= cnt_nx;
            dir        <= dir_nx;
            valley_hit <= live && (cnt_nx == '0);
            peak_hit   <= live && (dir_nx == DIR_UP) && (cnt_nx == period);
        end else begin
            valley_hit <= 1'b0;
            peak_hit   <= 1'b0;
        end
    end

    a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && period != '0 && cnt <= period && $stable(period))
        |=> (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));
    a_r1_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    a_r5_single_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !(valley_hit && peak_hit));
endmodule

// File: rtl/mp_rep_ctr.sv
// Half-period repetition counter: update on every (rep+1)-th boundary.
// Starts at 1 so the first update after reset lands on the first valley.
module mp_rep_ctr #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valley_hit,
    input  logic             peak_hit,
    input  logic [REP_W-1:0] rep,
    output logic             upd,
    output logic             samp
);
    localparam logic [REP_W-1:0] RST_LEFT = {{(REP_W-1){1'b0}}, 1'b1};

    logic [REP_W-1:0] left;
    logic             boundary;

    // Event decode from the registered boundary flags.
    always_comb begin
        boundary = valley_hit || peak_hit;
        upd      = boundary && (left == '0);
        samp     = upd && valley_hit;
    end

    // Boundaries remaining before the next update; reload from rep.
    always_ff @(posedge clk) begin
        if (!rst_n)        left <= RST_LEFT;
        else if (upd)      left <= rep;
        else if (boundary) left <= left - 1'b1;
    end

    a_r5_upd_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);
    a_r8_reload_from_rep: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (left == $past(rep)));
endmodule

// File: rtl/mp_compare.sv
// Active compare register, loaded from the shadow only on update,
// and the strict less-than comparator that forms the PWM output.
module mp_compare #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [CNT_W-1:0] shadow,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp_act,
    output logic             pwm
);
    // Shadow-to-active transfer at update.
    always_ff @(posedge clk) begin
        if (!rst_n)   cmp_act <= '0;
        else if (upd) cmp_act <= shadow;
    end

    // Output high below the compare.
    always_comb pwm = (cnt < cmp_act);

    a_r7_hold_between_upd: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(cmp_act));
    a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act == '0) |-> !pwm);
endmodule

// File: rtl/cpwm_midsample.sv
// Center-aligned PWM with an update event tied to the on-time midpoint.
// Assumes a single clock; all inputs synchronous to clk.
module cpwm_midsample #(
    parameter int CNT_W = 12,
    parameter int REP_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic [CNT_W-1:0] period_i,
    input  logic [REP_W-1:0] rep_i,
    input  logic [CNT_W-1:0] duty_shadow_i,
    output logic             pwm_o,
    output logic             upd_o,
    output logic             samp_o
);
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             valley_hit;
    logic             peak_hit;
    logic [CNT_W-1:0] cmp_act;

    mp_tick_gen #(.SEL_W(SEL_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .sel(presc_sel), .tick(tick)
    );

    mp_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(period_i),
        .cnt(cnt), .valley_hit(valley_hit), .peak_hit(peak_hit)
    );

    mp_rep_ctr #(.REP_W(REP_W)) u_rep (
        .clk(clk), .rst_n(rst_n), .valley_hit(valley_hit), .peak_hit(peak_hit),
        .rep(rep_i), .upd(upd_o), .samp(samp_o)
    );

    mp_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .upd(upd_o), .shadow(duty_shadow_i),
        .cnt(cnt), .cmp_act(cmp_act), .pwm(pwm_o)
    );

    a_r6_samp_at_valley: assert property (@(posedge clk) disable iff (!rst_n)
        samp_o |-> (upd_o && cnt == '0));
    a_r3_high_below_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= cmp_act) |-> !pwm_o);
endmodule

// File: tb/cpwm_midsample_bench.sv
`timescale 1ns/1ps
module cpwm_midsample_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  presc_sel = '0;
    logic [11:0] period_i = 12'd4;
    logic [7:0]  rep_i = 8'd1;
    logic [11:0] duty_shadow_i = '0;
    logic        pwm_o, upd_o, samp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpwm_midsample u_cpwm_midsample (
        .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .period_i(period_i),
        .rep_i(rep_i), .duty_shadow_i(duty_shadow_i),
        .pwm_o(pwm_o), .upd_o(upd_o), .samp_o(samp_o)
    );

    // Vectors: sel, period, rep, duty; expected high clocks, updates, samples
    // over a window of 2*(rep+1)*P*divide clocks following a sampled update.
    localparam int NV = 7;
    localparam int V_SEL[NV] = '{0, 1, 2, 3, 0, 0, 0};
    localparam int V_P  [NV] = '{4, 5, 3, 4, 6, 6, 10};
    localparam int V_REP[NV] = '{1, 3, 0, 2, 1, 3, 5};
    localparam int V_DTY[NV] = '{2, 3, 1, 4, 0, 7, 5};
    localparam int V_HI [NV] = '{6, 40, 4, 168, 0, 48, 54};
    localparam int V_U  [NV] = '{2, 2, 2, 2, 2, 2, 2};
    localparam int V_S  [NV] = '{2, 2, 1, 1, 2, 2, 2};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Count negedges until samp_o is seen (0 if never within the limit).
    task automatic wait_samp(output int n);
        n = 0;
        for (int i = 1; i <= 4000; i++) begin
            @(negedge clk);
            if (samp_o) begin n = i; return; end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int w, hi, nu, ns, g;
        // R9: outputs low while reset is held.
        duty_shadow_i = 12'd3;
        repeat (2) @(negedge clk);
        check("R9 pwm in reset", pwm_o, 0);
        check("R9 upd in reset", upd_o, 0);
        check("R9 samp in reset", samp_o, 0);
        // R5: first update at first valley, 2*P clocks after release.
        rst_n = 1'b1;
        wait_samp(w);
        check("R5 first update delay", w, 8);

        // Vector table: R2, R3, R4, R5, R6.
        for (int v = 0; v < NV; v++) begin
            presc_sel = 2'(V_SEL[v]); period_i = 12'(V_P[v]);
            rep_i = 8'(V_REP[v]); duty_shadow_i = 12'(V_DTY[v]);
            do_reset();
            wait_samp(w);
            hi = 0; nu = 0; ns = 0;
            for (int i = 0; i < 2 * (V_REP[v] + 1) * V_P[v] * (1 << V_SEL[v]); i++) begin
                @(negedge clk);
                hi += int'(pwm_o); nu += int'(upd_o); ns += int'(samp_o);
            end
            check($sformatf("R3 R4 v%0d high clocks", v), hi, V_HI[v]);
            check($sformatf("R5 v%0d updates", v), nu, V_U[v]);
            check($sformatf("R6 v%0d samples", v), ns, V_S[v]);
        end

        // R1: sample gap is one carrier period (P=6, divide 1).
        presc_sel = 2'd0; period_i = 12'd6; rep_i = 8'd1; duty_shadow_i = 12'd2;
        do_reset(); wait_samp(w); wait_samp(g);
        check("R1 carrier period clocks", g, 12);
        // R2: divide 4 stretches the period (P=3).
        presc_sel = 2'd2; period_i = 12'd3;
        do_reset(); wait_samp(w); wait_samp(g);
        check("R2 prescaled period clocks", g, 24);
        // R1: period 0 holds the carrier, no update.
        presc_sel = 2'd0; period_i = 12'd0;
        do_reset(); wait_samp(w);
        check("R1 zero period no sample", w, 0);

        // R7: shadow written between updates has no effect until the next one.
        period_i = 12'd4; rep_i = 8'd1; duty_shadow_i = 12'd2;
        do_reset(); wait_samp(w);
        hi = 0;
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            if (i == 2) duty_shadow_i = 12'd4;
            hi += int'(pwm_o);
        end
        check("R7 old duty held", hi, 2);
        @(negedge clk);
        check("R7 update after change", upd_o, 1);
        hi = 0;
        for (int i = 9; i <= 15; i++) begin
            @(negedge clk);
            hi += int'(pwm_o);
        end
        check("R7 new duty applied", hi, 6);

        // R8: a new REP applies only after the next reload.
        duty_shadow_i = 12'd2; rep_i = 8'd1;
        do_reset(); wait_samp(w);
        nu = 0;
        for (int i = 1; i <= 23; i++) begin
            @(negedge clk);
            if (i == 2) rep_i = 8'd3;
            nu += int'(upd_o);
        end
        check("R8 updates before new spacing", nu, 1);
        @(negedge clk);
        check("R8 update at new spacing", upd_o, 1);

        finish_run();
    end
endmodule